// File: doc/BRIEF.md
# Secondary Scan Chain Splicer

This block sits beside a boundary-scan test port and splices up to four secondary scan chains into the primary serial path between TDI and TDO. An 8-bit select value is shifted in while its scan instruction is active, then committed through the TAP state sequence. Each 2-bit field of the committed value tells its chain whether its mode-select line sits at a static level or follows TMS. The same field decides whether the chain's serial data output is driven during shifting.

Serial data runs through the selected chains in ascending chain order. The path passes one retiming flop per chain, and then hands off to the device's own instruction or data register. That register sits last and drives TDO. When a chain is newly selected while no other chain follows TMS, its mode-select line is parked low and only begins to follow at the next Run-Test/Idle. This lets the secondary TAP controllers start out in step. A global disable input turns off every downstream clock, data and mode-select driver. Tri-state pins are modelled as a data signal plus an output-enable signal.

Top module: `sspl_linker`

## Requirements
- R1: Asserting rst_ni, or a falling clock edge with the TAP state at Test-Logic-Reset (code 0), commits an all-zero select value: every chain mode-select is high, none follows TMS, and no chain data output is enabled. rst_ni also clears the select shift register.
- R2: Chain i is controlled by select bits [2i+1:2i]. Code 00 gives a static high mode-select, code 01 gives a static low one, and both leave the chain unselected. Codes 10 and 11 select the chain, and its mode-select follows TMS.
- R3: A chain's data-output enable is high only while the chain is selected and the TAP state is Shift-DR (code 4) or Shift-IR (code 11).
- R4: A new select value takes effect only on the falling clock edge with the TAP state at Update-DR (code 8) and sel_en_i high. Before that edge the mode-select outputs keep their previous configuration.
- R5: A chain that becomes selected while no chain currently follows TMS is held low. It starts following TMS at the first falling edge in Run-Test/Idle (code 1). Passing through other states, including a repeated Update-DR, keeps it low.
- R6: A chain that becomes selected while at least one other chain already follows TMS starts following at that same Update-DR falling edge. Whether another chain is following is judged on the configuration held before the update.
- R7: Serial data passes TDI, then each selected chain in ascending index order. Every selected chain's data output equals the value entering it, delayed by one rising clock edge. Unselected chains are skipped.
- R8: chain_o, the serial input of the device's internal register, equals the data input of the highest selected chain, or tdi_i when no chain is selected.
- R9: While out_dis_i is 1, the enables of the downstream clock, all mode-select outputs and all chain data outputs are 0, whatever the select value.
- R10: On each rising edge with sel_en_i high in Shift-DR, the select shift register shifts right and takes chain_o into bit 7. sel_so_o presents bit 0. Capture-DR does not load it, and it holds its value in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| tap_state_i | input | 4 | Current TAP controller state code |
| sel_en_i | input | 1 | Select-register scan instruction is active |
| tms_i | input | 1 | Primary test mode select |
| tdi_i | input | 1 | Primary serial data input |
| out_dis_i | input | 1 | Global disable of downstream drivers |
| dtdi_i | input | 4 | Serial returns from the secondary chains |
| dtck_o | output | 1 | Buffered test clock to the secondary chains |
| dtck_oe_o | output | 1 | Enable of dtck_o |
| dtms_o | output | 4 | Mode-select to each secondary chain |
| dtms_oe_o | output | 4 | Enables of dtms_o |
| dtdo_o | output | 4 | Serial data to each secondary chain |
| dtdo_oe_o | output | 4 | Enables of dtdo_o |
| chain_o | output | 1 | Serial data into the device's own register |
| sel_so_o | output | 1 | Serial output of the select shift register |

## Verification
The decisive coincidence is a single Update-DR falling edge at which some chains drop to static levels and others newly enter follow mode. The latter must look at which chains were following before that same edge, not after it. The bench steps through all 256 select values in order, so every consecutive pair of configurations meets at one commit edge. A reference model derived from the rules predicts each chain's level, with TMS checked at both values at that edge, at the preceding Exit1-DR and at the following Run-Test/Idle. Odd values also detour through Select-DR-Scan and a second Update-DR, to confirm that a parked chain stays low until Run-Test/Idle.

// File: rtl/sspl_pkg.sv
package sspl_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PS_DR  = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PS_IR  = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;
endpackage

// File: rtl/sspl_select_reg.sv
module sspl_select_reg #(
  parameter int SEL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             upd_i,
  input  logic             tlr_i,
  input  logic             si_i,
  output logic [SEL_W-1:0] sh_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             so_o
);
  logic [SEL_W-1:0] sh_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {si_i, sh_q[SEL_W-1:1]};
  end

  // commit on the falling edge so the downstream config switches mid-cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= '0;
    else if (tlr_i) sel_q <= '0;
    else if (upd_i) sel_q <= sh_q;
  end

  assign sh_o  = sh_q;
  assign sel_o = sel_q;
  assign so_o  = sh_q[0];
endmodule

// File: rtl/sspl_tms_seq.sv
module sspl_tms_seq import sspl_pkg::*; #(
  parameter int N_CHAIN = 4,
  localparam int SEL_W  = N_CHAIN * FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               tlr_i,
  input  logic               rti_i,
  input  logic [SEL_W-1:0]   nv_i,
  input  logic               tms_i,
  output logic [N_CHAIN-1:0] dtms_o
);
  logic [N_CHAIN-1:0] follow_q, pend_q, lvl_q;
  logic [N_CHAIN-1:0] follow_d, pend_d, lvl_d;

  always_comb begin
    follow_d = follow_q;
    pend_d   = pend_q;
    lvl_d    = lvl_q;
    if (tlr_i) begin
      follow_d = '0;
      pend_d   = '0;
      lvl_d    = '1;
    end else if (upd_i) begin
      for (int i = 0; i < N_CHAIN; i++) begin
        if (!nv_i[FIELD_W*i+1]) begin
          follow_d[i] = 1'b0;
          pend_d[i]   = 1'b0;
          lvl_d[i]    = ~nv_i[FIELD_W*i];
        end else if (!follow_q[i]) begin
          // judged on pre-update followers
          if (|follow_q) begin
            follow_d[i] = 1'b1;
            pend_d[i]   = 1'b0;
          end else begin
            pend_d[i] = 1'b1;
            lvl_d[i]  = 1'b0;
          end
        end
      end
    end else if (rti_i) begin
      follow_d = follow_q | pend_q;
      pend_d   = '0;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      follow_q <= '0;
      pend_q   <= '0;
      lvl_q    <= '1;
    end else begin
      follow_q <= follow_d;
      pend_q   <= pend_d;
      lvl_q    <= lvl_d;
    end
  end

  for (genvar i = 0; i < N_CHAIN; i++) begin : g_mux
    assign dtms_o[i] = follow_q[i] ? tms_i : lvl_q[i];
  end
endmodule

// File: rtl/sspl_route.sv
module sspl_route #(
  parameter int N_CHAIN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  logic [N_CHAIN-1:0] dtdi_i,
  input  logic [N_CHAIN-1:0] sel_mask_i,
  output logic [N_CHAIN-1:0] dtdo_o,
  output logic               chain_o
);
  logic [N_CHAIN:0] link;

  assign link[0] = tdi_i;

  for (genvar i = 0; i < N_CHAIN; i++) begin : g_hop
    assign link[i+1] = sel_mask_i[i] ? dtdi_i[i] : link[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dtdo_o[i] <= 1'b0;
      else         dtdo_o[i] <= link[i];
    end
  end

  assign chain_o = link[N_CHAIN];
endmodule

// File: rtl/sspl_linker.sv
module sspl_linker import sspl_pkg::*; #(
  parameter int N_CHAIN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         tap_state_i,
  input  logic               sel_en_i,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic               out_dis_i,
  input  logic [N_CHAIN-1:0] dtdi_i,
  output logic               dtck_o,
  output logic               dtck_oe_o,
  output logic [N_CHAIN-1:0] dtms_o,
  output logic [N_CHAIN-1:0] dtms_oe_o,
  output logic [N_CHAIN-1:0] dtdo_o,
  output logic [N_CHAIN-1:0] dtdo_oe_o,
  output logic               chain_o,
  output logic               sel_so_o
);
  localparam int SEL_W = N_CHAIN * FIELD_W;

  tap_state_e         st;
  logic               shift_any, sel_shift, sel_upd, tlr, rti;
  logic [SEL_W-1:0]   sel_sh, sel_q;
  logic [N_CHAIN-1:0] sel_mask;

  assign st        = tap_state_e'(tap_state_i);
  assign shift_any = (st == ST_SH_DR) || (st == ST_SH_IR);
  assign sel_shift = sel_en_i && (st == ST_SH_DR);
  assign sel_upd   = sel_en_i && (st == ST_UPD_DR);
  assign tlr       = (st == ST_TLR);
  assign rti       = (st == ST_RTI);

  for (genvar i = 0; i < N_CHAIN; i++) begin : g_mask
    assign sel_mask[i] = sel_q[FIELD_W*i+1];
  end

  sspl_select_reg #(.SEL_W(SEL_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sel_shift),
    .upd_i  (sel_upd),
    .tlr_i  (tlr),
    .si_i   (chain_o),
    .sh_o   (sel_sh),
    .sel_o  (sel_q),
    .so_o   (sel_so_o)
  );

  sspl_tms_seq #(.N_CHAIN(N_CHAIN)) u_tms (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (sel_upd),
    .tlr_i  (tlr),
    .rti_i  (rti),
    .nv_i   (sel_sh),
    .tms_i  (tms_i),
    .dtms_o (dtms_o)
  );

  sspl_route #(.N_CHAIN(N_CHAIN)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tdi_i     (tdi_i),
    .dtdi_i    (dtdi_i),
    .sel_mask_i(sel_mask),
    .dtdo_o    (dtdo_o),
    .chain_o   (chain_o)
  );

  assign dtck_o    = clk_i;
  assign dtck_oe_o = ~out_dis_i;
  assign dtms_oe_o = {N_CHAIN{~out_dis_i}};
  assign dtdo_oe_o = sel_mask & {N_CHAIN{shift_any & ~out_dis_i}};
endmodule

// File: rtl/sspl_linker_chk.sv
module sspl_linker_chk import sspl_pkg::*; #(
  parameter int N_CHAIN = 4,
  localparam int SEL_W  = N_CHAIN * FIELD_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         tap_state_i,
  input logic               tdi_i,
  input logic               out_dis_i,
  input logic               dtck_oe_o,
  input logic [N_CHAIN-1:0] dtms_o,
  input logic [N_CHAIN-1:0] dtms_oe_o,
  input logic [N_CHAIN-1:0] dtdo_o,
  input logic [N_CHAIN-1:0] dtdo_oe_o,
  input logic [SEL_W-1:0]   sel_q_i
);
  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dis_i |-> (!dtck_oe_o && dtms_oe_o == '0 && dtdo_oe_o == '0));

  a_r3_shift_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtdo_oe_o != '0) |-> (tap_state_i == ST_SH_DR || tap_state_i == ST_SH_IR));

  a_r4_commit_edge: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(tap_state_i == ST_UPD_DR || tap_state_i == ST_TLR) |=> $stable(sel_q_i));

  a_r7_first_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_dis_i |=> dtdo_o[0] == $past(tdi_i));

  for (genvar i = 0; i < N_CHAIN; i++) begin : g_chain
    a_r3_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dtdo_oe_o[i] |-> sel_q_i[FIELD_W*i+1]);

    a_r2_static_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_q_i[FIELD_W*i+1] && dtms_oe_o[i]) |-> dtms_o[i] == !sel_q_i[FIELD_W*i]);
  end
endmodule

bind sspl_linker sspl_linker_chk #(.N_CHAIN(N_CHAIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tap_state_i(tap_state_i),
  .tdi_i      (tdi_i),
  .out_dis_i  (out_dis_i),
  .dtck_oe_o  (dtck_oe_o),
  .dtms_o     (dtms_o),
  .dtms_oe_o  (dtms_oe_o),
  .dtdo_o     (dtdo_o),
  .dtdo_oe_o  (dtdo_oe_o),
  .sel_q_i    (sel_q)
);

// File: tb/sspl_linker_test.sv
module sspl_linker_test;
  localparam logic [3:0] S_TLR = 4'd0, S_RTI = 4'd1, S_SELDR = 4'd2, S_CAPDR = 4'd3,
    S_SHDR = 4'd4, S_EX1DR = 4'd5, S_PSDR = 4'd6, S_EX2DR = 4'd7, S_UPDR = 4'd8,
    S_SELIR = 4'd9, S_CAPIR = 4'd10, S_SHIR = 4'd11, S_EX1IR = 4'd12, S_PSIR = 4'd13,
    S_EX2IR = 4'd14, S_UPIR = 4'd15;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] tap_state_i = S_TLR;
  logic       sel_en_i = 1'b0, tms_i = 1'b1, tdi_i = 1'b0, out_dis_i = 1'b0;
  logic [3:0] dtdi;
  logic       dtck_o, dtck_oe_o, chain_o, sel_so_o;
  logic [3:0] dtms_o, dtms_oe_o, dtdo_o, dtdo_oe_o;

  // zero-length secondary chains: each return is looped back
  assign dtdi = dtdo_o;

  sspl_linker uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tap_state_i(tap_state_i), .sel_en_i(sel_en_i),
    .tms_i(tms_i), .tdi_i(tdi_i), .out_dis_i(out_dis_i), .dtdi_i(dtdi),
    .dtck_o(dtck_o), .dtck_oe_o(dtck_oe_o), .dtms_o(dtms_o), .dtms_oe_o(dtms_oe_o),
    .dtdo_o(dtdo_o), .dtdo_oe_o(dtdo_oe_o), .chain_o(chain_o), .sel_so_o(sel_so_o)
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_sel = '0, wr_val = '0, hist = '0, lf = 8'h5b;
  logic [3:0] m_fol = '0, m_pend = '0, m_lvl = 4'hf;

  function automatic logic [3:0] nxt(input logic [3:0] s, input logic t);
    case (s)
      S_TLR:   return t ? S_TLR   : S_RTI;
      S_RTI:   return t ? S_SELDR : S_RTI;
      S_SELDR: return t ? S_SELIR : S_CAPDR;
      S_CAPDR: return t ? S_EX1DR : S_SHDR;
      S_SHDR:  return t ? S_EX1DR : S_SHDR;
      S_EX1DR: return t ? S_UPDR  : S_PSDR;
      S_PSDR:  return t ? S_EX2DR : S_PSDR;
      S_EX2DR: return t ? S_UPDR  : S_SHDR;
      S_UPDR:  return t ? S_SELDR : S_RTI;
      S_SELIR: return t ? S_TLR   : S_CAPIR;
      S_CAPIR: return t ? S_EX1IR : S_SHIR;
      S_SHIR:  return t ? S_EX1IR : S_SHIR;
      S_EX1IR: return t ? S_UPIR  : S_PSIR;
      S_PSIR:  return t ? S_EX2IR : S_PSIR;
      S_EX2IR: return t ? S_UPIR  : S_SHIR;
      default: return t ? S_SELDR : S_RTI;
    endcase
  endfunction

  function automatic logic [3:0] mask_of(input logic [7:0] v);
    return {v[7], v[5], v[3], v[1]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model of the falling-edge configuration stage
  task automatic model_edge();
    if (tap_state_i == S_TLR) begin
      m_sel = '0; m_fol = '0; m_pend = '0; m_lvl = 4'hf;
    end else if (tap_state_i == S_UPDR && sel_en_i) begin
      logic any_f;
      any_f = |m_fol;
      for (int i = 0; i < 4; i++) begin
        if (!wr_val[2*i+1]) begin
          m_fol[i] = 1'b0; m_pend[i] = 1'b0; m_lvl[i] = !wr_val[2*i];
        end else if (!m_fol[i]) begin
          if (any_f) begin m_fol[i] = 1'b1; m_pend[i] = 1'b0; end
          else begin m_pend[i] = 1'b1; m_lvl[i] = 1'b0; end
        end
      end
      m_sel = wr_val;
    end else if (tap_state_i == S_RTI) begin
      m_fol = m_fol | m_pend;
      m_pend = '0;
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms_i = t; tdi_i = d;
    @(posedge clk_i);
    hist = {hist[6:0], d};
    #2;
    tap_state_i = nxt(tap_state_i, t);
    model_edge();
    @(negedge clk_i);
    #3;
  endtask

  function automatic logic [3:0] exp_dtms();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = m_fol[i] ? tms_i : m_lvl[i];
    return e;
  endfunction

  task automatic chk_cfg(input string tag);
    logic [3:0] eo;
    chk(tag, "dtms", {4'h0, dtms_o}, {4'h0, exp_dtms()});
    tms_i = ~tms_i; #1;
    chk(tag, "dtms tms flipped", {4'h0, dtms_o}, {4'h0, exp_dtms()});
    tms_i = ~tms_i; #1;
    chk(tag, "dtms_oe", {4'h0, dtms_oe_o}, 8'h0f);
    eo = (tap_state_i == S_SHDR || tap_state_i == S_SHIR) ? mask_of(m_sel) : 4'h0;
    chk(tag, "dtdo_oe", {4'h0, dtdo_oe_o}, {4'h0, eo});
  endtask

  // from Run-Test/Idle, shift v then pad by the current chain delay; ends in Exit1-DR
  task automatic write_sel(input logic [7:0] v);
    int k, tot;
    k = $countones(mask_of(m_sel));
    tot = 8 + k;
    wr_val = v;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int b = 0; b < tot; b++) step(b == tot - 1, (b < 8) ? v[b] : 1'b0);
  endtask

  initial begin
    #(64'd20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    @(negedge clk_i); #3;
    // R1 reset state
    chk("R1", "dtms", {4'h0, dtms_o}, 8'h0f);
    chk("R1", "dtdo_oe", {4'h0, dtdo_oe_o}, 8'h00);
    chk("R1", "sel_so", {7'h0, sel_so_o}, 8'h00);
    chk("R9", "dtck_oe enabled", {7'h0, dtck_oe_o}, 8'h01);
    chk("R8", "chain_o no select", {7'h0, chain_o}, {7'h0, tdi_i});
    step(1'b0, 1'b0);

    // sweep every select value: R2 decode, R4 commit timing, R5 park, R6 handover, R10
    sel_en_i = 1'b1;
    for (int v = 0; v < 256; v++) begin
      write_sel(8'(v));
      chk_cfg("R4 before update");
      chk("R10", "sel_so after shift", {7'h0, sel_so_o}, {7'h0, wr_val[0]});
      step(1'b1, 1'b0);
      chk_cfg("R2 R5 R6 at update");
      if (v[0]) begin
        step(1'b1, 1'b0);
        chk_cfg("R5 parked in select");
        step(1'b0, 1'b0);
        chk("R10", "no capture load", {7'h0, sel_so_o}, {7'h0, wr_val[0]});
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk_cfg("R5 R6 second update");
      end
      step(1'b0, 1'b0);
      chk_cfg("R5 at idle");
    end

    // routing over all chain subsets: R7, R8, R3, R9
    for (int s = 0; s < 16; s++) begin
      logic [7:0] v;
      int k;
      v = '0;
      for (int i = 0; i < 4; i++) v[2*i+1] = s[i];
      sel_en_i = 1'b1;
      write_sel(v);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      sel_en_i = 1'b0;
      k = $countones(s[3:0]);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      for (int n = 0; n < 12; n++) begin
        step(1'b0, lf[0]);
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[4], lf[7:1]};
        if (n >= 4) begin
          for (int j = 0; j < 4; j++) begin
            if (s[j]) begin
              int r;
              r = $countones(s[3:0] & ((1 << j) - 1));
              chk("R7", "dtdo hop", {7'h0, dtdo_o[j]}, {7'h0, hist[r]});
            end
          end
          chk("R8", "chain_o", {7'h0, chain_o}, {7'h0, (k == 0) ? tdi_i : hist[k-1]});
          chk("R3", "dtdo_oe in shift", {4'h0, dtdo_oe_o}, {4'h0, s[3:0]});
        end
        if (n == 6) begin
          out_dis_i = 1'b1; #1;
          chk("R9", "dtck_oe", {7'h0, dtck_oe_o}, 8'h00);
          chk("R9", "dtms_oe", {4'h0, dtms_oe_o}, 8'h00);
          chk("R9", "dtdo_oe", {4'h0, dtdo_oe_o}, 8'h00);
          out_dis_i = 1'b0; #1;
        end
      end
      step(1'b1, 1'b0);
      chk("R3", "dtdo_oe exit", {4'h0, dtdo_oe_o}, 8'h00);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
    end

    // R1: Test-Logic-Reset clears an active selection
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    chk("R1", "state", {4'h0, tap_state_i}, {4'h0, S_TLR});
    chk("R1", "dtms after tlr", {4'h0, dtms_o}, 8'h0f);
    chk_cfg("R1 tlr");
    step(1'b0, 1'b0);
    chk("R1", "no follow after tlr", {4'h0, dtms_o}, 8'h0f);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule